// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block brings a DDR3 memory from power-on to a usable state with no processor and no instruction memory involved. After a start pulse it walks a fixed program: it takes the PHY under local control, lifts the memory reset, raises clock enable, programs the four mode registers, runs ZQ calibration, and finally hands the PHY back to the regular memory controller. Every memory command goes out on a single-phase command port (row address, bank address, four command strobes) and is marked by a one-cycle issue pulse. The PHY control bits go out as a four-bit word.

The long settling pauses between stages are timed in clock cycles taken from a clock-frequency parameter. A second parameter shortens them for simulation. Once finished, the block holds its outputs and raises `init_done` until the next reset.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While reset is held and after it is released, before any start, `ctl_word`, `cmd_word`, `dfi_addr`, `dfi_bank`, `cmd_issue` and `init_done` are all zero.
- R2: Control word bit positions: bit0 hands the PHY to the normal controller, bit1 is clock enable, bit2 is on-die termination, bit3 is the active-low memory reset. Command word: bit0 chip select, bit1 write enable, bit2 column strobe, bit3 row strobe.
- R3: If start is sampled high in the idle state at clock edge s, `ctl_word` becomes 0xC (termination plus reset released) at edge s+N+3, with address and bank at zero. N is the wait length.
- R4: `ctl_word` changes from 0xC to 0xE (clock enable added) exactly N+2 cycles later.
- R5: Four mode-register loads follow, each with command 0xF. Their issue pulses fall at edges s+3N+8, +10, +12 and +14, and they carry, in this order, bank 2 / address 0x408, bank 3 / 0x0, bank 1 / 0x6, then bank 0 / 0x930.
- R6: `cmd_issue` is high for exactly one cycle per command. Address, bank and command are loaded one cycle before it and do not change during it.
- R7: ZQ calibration issues at edge s+4N+17 with address 0x400, bank 0 and command 0x3.
- R8: `ctl_word` becomes 0x1 (controller owns the PHY) at edge s+5N+19. `init_done` rises one cycle later and stays high with all outputs frozen. Over the whole run `ctl_word` changes exactly three times and exactly five commands issue.
- R9: N equals SIM_WAIT_CYC when that parameter is nonzero, otherwise CLK_HZ/10. During every wait no output changes.
- R10: A start pulse while the program runs, or after it has finished, has no effect on any output or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the program when the block is idle |
| dfi_addr | output | ADDR_W | Address for the current command |
| dfi_bank | output | BANK_W | Bank address for the current command |
| cmd_word | output | 4 | Command strobes {RAS, CAS, WE, CS} |
| cmd_issue | output | 1 | One-cycle strobe that issues the loaded command |
| ctl_word | output | 4 | PHY control {RESET_N, ODT, CKE, SEL} |
| init_done | output | 1 | High once the program has completed |

## Verification
Every result is due at an exact edge counted from the edge that samples start. The first control change is due N+3 edges later, and each later stage is N+2 edges after the previous one. Commands issue one edge after their operands load, and done follows the final control write by one edge. The bench counts clock edges, samples on the falling edge, and compares the recorded edge of every control change and issue pulse with those formulas. A second instance with SIM_WAIT_CYC at zero confirms the wait length derived from the frequency.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  typedef enum logic [1:0] {
    OP_WAIT = 2'd0,
    OP_CTL  = 2'd1,
    OP_CMD  = 2'd2,
    OP_END  = 2'd3
  } op_e;

  // control word bits
  localparam logic [3:0] CW_SEL  = 4'b0001;
  localparam logic [3:0] CW_CKE  = 4'b0010;
  localparam logic [3:0] CW_ODT  = 4'b0100;
  localparam logic [3:0] CW_RSTN = 4'b1000;
  // command word bits
  localparam logic [3:0] CM_CS   = 4'b0001;
  localparam logic [3:0] CM_WE   = 4'b0010;
  localparam logic [3:0] CM_CAS  = 4'b0100;
  localparam logic [3:0] CM_RAS  = 4'b1000;

  localparam int PC_W = 4;

  typedef struct packed {
    op_e         op;
    logic [3:0]  ctl;
    logic [15:0] addr;
    logic [2:0]  bank;
    logic [3:0]  cmd;
  } step_t;

  // wait length in cycles: simulation override or a tenth of a second
  function automatic int unsigned wait_len(input int unsigned clk_hz,
                                           input int unsigned sim_cyc);
    int unsigned n;
    n = (sim_cyc != 0) ? sim_cyc : clk_hz / 10;
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic step_t mk(input op_e op, input logic [3:0] ctl,
                               input logic [15:0] addr, input logic [2:0] bank,
                               input logic [3:0] cmd);
    step_t s;
    s.op = op; s.ctl = ctl; s.addr = addr; s.bank = bank; s.cmd = cmd;
    return s;
  endfunction

  // the fixed power-up program
  function automatic step_t step_at(input logic [PC_W-1:0] pc);
    logic [3:0] mrs;
    mrs = CM_RAS | CM_CAS | CM_WE | CM_CS;
    case (pc)
      4'd0:    return mk(OP_WAIT, 4'h0, 16'h0, 3'd0, 4'h0);
      4'd1:    return mk(OP_CTL, 4'h0, 16'h0, 3'd0, 4'h0);
      4'd2:    return mk(OP_CTL, CW_ODT | CW_RSTN, 16'h0, 3'd0, 4'h0);
      4'd3:    return mk(OP_WAIT, 4'h0, 16'h0, 3'd0, 4'h0);
      4'd4:    return mk(OP_CTL, CW_CKE | CW_ODT | CW_RSTN, 16'h0, 3'd0, 4'h0);
      4'd5:    return mk(OP_WAIT, 4'h0, 16'h0, 3'd0, 4'h0);
      4'd6:    return mk(OP_CMD, 4'h0, 16'h0408, 3'd2, mrs);
      4'd7:    return mk(OP_CMD, 4'h0, 16'h0000, 3'd3, mrs);
      4'd8:    return mk(OP_CMD, 4'h0, 16'h0006, 3'd1, mrs);
      4'd9:    return mk(OP_CMD, 4'h0, 16'h0930, 3'd0, mrs);
      4'd10:   return mk(OP_WAIT, 4'h0, 16'h0, 3'd0, 4'h0);
      4'd11:   return mk(OP_CMD, 4'h0, 16'h0400, 3'd0, CM_WE | CM_CS);
      4'd12:   return mk(OP_WAIT, 4'h0, 16'h0, 3'd0, 4'h0);
      4'd13:   return mk(OP_CTL, CW_SEL, 16'h0, 3'd0, 4'h0);
      default: return mk(OP_END, 4'h0, 16'h0, 3'd0, 4'h0);
    endcase
  endfunction

endpackage

// File: rtl/ddr3_pwrup_steprom.sv
module ddr3_pwrup_steprom
  import ddr3_pwrup_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  output step_t           step
);
  always_comb step = step_at(pc);
endmodule

// File: rtl/ddr3_pwrup_timer.sv
module ddr3_pwrup_timer #(
  parameter int unsigned WAIT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic expire
);
  localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= LOAD_VAL;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign busy   = active;
  assign expire = active && (cnt == '0);

  AST_TMR_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !busy); // R9
  AST_TMR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load); // R9
endmodule

// File: rtl/ddr3_pwrup_drive.sv
module ddr3_pwrup_drive #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ctl,
  input  logic [3:0]        ctl_val,
  input  logic              ld_cmd,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [BANK_W-1:0] bank_val,
  input  logic [3:0]        cmd_val,
  input  logic              fire,
  output logic [3:0]        ctl_word,
  output logic [ADDR_W-1:0] dfi_addr,
  output logic [BANK_W-1:0] dfi_bank,
  output logic [3:0]        cmd_word,
  output logic              cmd_issue
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_word  <= '0;
      dfi_addr  <= '0;
      dfi_bank  <= '0;
      cmd_word  <= '0;
      cmd_issue <= 1'b0;
    end else begin
      cmd_issue <= fire;
      if (ld_ctl) ctl_word <= ctl_val;
      if (ld_cmd) begin
        dfi_addr <= addr_val;
        dfi_bank <= bank_val;
        cmd_word <= cmd_val;
      end
    end
  end

  AST_ISSUE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !cmd_issue); // R6
  AST_ISSUE_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> ($stable(dfi_addr) && $stable(dfi_bank) && $stable(cmd_word))); // R6
  AST_ISSUE_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> (cmd_word[0] == 1'b1)); // R2
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned SIM_WAIT_CYC = 0,
  parameter int          ADDR_W       = 14,
  parameter int          BANK_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] dfi_addr,
  output logic [BANK_W-1:0] dfi_bank,
  output logic [3:0]        cmd_word,
  output logic              cmd_issue,
  output logic [3:0]        ctl_word,
  output logic              init_done
);
  localparam int unsigned WAIT_CYC = wait_len(CLK_HZ, SIM_WAIT_CYC);

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_ISSUE, ST_WAIT, ST_DONE
  } state_e;

  state_e          state, state_nx;
  logic [PC_W-1:0] pc, pc_nx;
  step_t           step;

  logic tmr_load, tmr_busy, tmr_expire;
  logic ld_ctl, ld_cmd, fire;

  ddr3_pwrup_steprom u_rom (.pc(pc), .step(step));

  ddr3_pwrup_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .busy(tmr_busy), .expire(tmr_expire)
  );

  ddr3_pwrup_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .ld_ctl(ld_ctl), .ctl_val(step.ctl),
    .ld_cmd(ld_cmd), .addr_val(step.addr[ADDR_W-1:0]),
    .bank_val(step.bank[BANK_W-1:0]), .cmd_val(step.cmd),
    .fire(fire),
    .ctl_word(ctl_word), .dfi_addr(dfi_addr), .dfi_bank(dfi_bank),
    .cmd_word(cmd_word), .cmd_issue(cmd_issue)
  );

  always_comb begin
    state_nx = state;
    pc_nx    = pc;
    tmr_load = 1'b0;
    ld_ctl   = 1'b0;
    ld_cmd   = 1'b0;
    fire     = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        state_nx = ST_EXEC;
        pc_nx    = '0;
      end
      ST_EXEC: case (step.op)
        OP_WAIT: begin tmr_load = 1'b1; state_nx = ST_WAIT; end
        OP_CTL:  begin ld_ctl = 1'b1; pc_nx = pc + 1'b1; end
        OP_CMD:  begin ld_cmd = 1'b1; state_nx = ST_ISSUE; end
        default: state_nx = ST_DONE;
      endcase
      ST_ISSUE: begin
        fire     = 1'b1;
        pc_nx    = pc + 1'b1;
        state_nx = ST_EXEC;
      end
      ST_WAIT: if (tmr_expire) begin
        pc_nx    = pc + 1'b1;
        state_nx = ST_EXEC;
      end
      default: state_nx = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
    end else begin
      state <= state_nx;
      pc    <= pc_nx;
    end
  end

  assign init_done = (state == ST_DONE);

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_IDLE)); // R10
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |=> ($stable(ctl_word) && $stable(cmd_word) && $stable(dfi_addr))); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && $stable(ctl_word) && !cmd_issue)); // R8
  AST_DONE_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (ctl_word == CW_SEL)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (ctl_word == 4'h0 && !cmd_issue)); // R1
endmodule

// File: tb/ddr3_pwrup_seq_tb.sv
module ddr3_pwrup_seq_tb;
  localparam int N  = 20;
  localparam int NS = 40;  // 400 Hz / 10

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [13:0] addr;  logic [2:0] bank;  logic [3:0] cmd, ctl;
  logic issue, done;
  logic [13:0] addr_s; logic [2:0] bank_s; logic [3:0] cmd_s, ctl_s;
  logic issue_s, done_s;

  ddr3_pwrup_seq #(.CLK_HZ(200_000_000), .SIM_WAIT_CYC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dfi_addr(addr), .dfi_bank(bank),
    .cmd_word(cmd), .cmd_issue(issue), .ctl_word(ctl), .init_done(done));

  ddr3_pwrup_seq #(.CLK_HZ(400), .SIM_WAIT_CYC(0)) u_dut_slow (
    .clk(clk), .rst_n(rst_n), .start(start), .dfi_addr(addr_s), .dfi_bank(bank_s),
    .cmd_word(cmd_s), .cmd_issue(issue_s), .ctl_word(ctl_s), .init_done(done_s));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int s_cyc, n_iss, n_ctl, done_cyc, slow_cyc, hold_bad;
  int iss_cyc[8]; logic [13:0] iss_addr[8]; logic [2:0] iss_bank[8]; logic [3:0] iss_cmd[8];
  int ctl_cyc[8]; logic [3:0] ctl_val[8];

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    s_cyc = cyc;  // edge that sampled start
  endtask

  task automatic record(input int span, input int x1, input int x2);
    logic [3:0] p_ctl, p_cmd; logic [13:0] p_addr; logic [2:0] p_bank; logic p_iss;
    n_iss = 0; n_ctl = 0; done_cyc = -1; slow_cyc = -1; hold_bad = 0;
    p_ctl = ctl; p_cmd = cmd; p_addr = addr; p_bank = bank; p_iss = issue;
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      start = (cyc == x1 || cyc == x2);
      if (ctl != p_ctl && n_ctl < 8) begin
        ctl_cyc[n_ctl] = cyc - s_cyc; ctl_val[n_ctl] = ctl; n_ctl++;
      end
      if (issue) begin
        if (p_iss || addr != p_addr || bank != p_bank || cmd != p_cmd) hold_bad++;
        if (n_iss < 8) begin
          iss_cyc[n_iss] = cyc - s_cyc; iss_addr[n_iss] = addr;
          iss_bank[n_iss] = bank; iss_cmd[n_iss] = cmd;
        end
        n_iss++;
      end
      if (done && done_cyc < 0) done_cyc = cyc - s_cyc;
      if (ctl_s == 4'hC && slow_cyc < 0) slow_cyc = cyc - s_cyc;
      p_ctl = ctl; p_cmd = cmd; p_addr = addr; p_bank = bank; p_iss = issue;
    end
    start = 1'b0;
  endtask

  task automatic check_program(input string tag);
    logic [13:0] ea[4] = '{14'h408, 14'h0, 14'h6, 14'h930};
    logic [2:0]  eb[4] = '{3'd2, 3'd3, 3'd1, 3'd0};
    chk({tag, " R3 first ctl edge"}, ctl_cyc[0], N + 3);
    chk({tag, " R3 first ctl value"}, ctl_val[0], 4'hC);
    chk({tag, " R4 cke edge"}, ctl_cyc[1], 2 * N + 5);
    chk({tag, " R2 cke at bit1"}, ctl_val[1] ^ ctl_val[0], 4'b0010);
    chk({tag, " R8 issue count"}, n_iss, 5);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " R5 mrs edge"}, iss_cyc[i], 3 * N + 8 + 2 * i);
      chk({tag, " R5 mrs addr"}, iss_addr[i], ea[i]);
      chk({tag, " R5 mrs bank"}, iss_bank[i], eb[i]);
      chk({tag, " R5 R2 mrs cmd"}, iss_cmd[i], 4'hF);
    end
    chk({tag, " R6 issue single and held"}, hold_bad, 0);
    chk({tag, " R7 zq edge"}, iss_cyc[4], 4 * N + 17);
    chk({tag, " R7 zq addr"}, iss_addr[4], 14'h400);
    chk({tag, " R7 zq bank"}, iss_bank[4], 0);
    chk({tag, " R7 R2 zq cmd"}, iss_cmd[4], 4'h3);
    chk({tag, " R8 ctl change count"}, n_ctl, 3);
    chk({tag, " R8 handover edge"}, ctl_cyc[2], 5 * N + 19);
    chk({tag, " R8 handover value"}, ctl_val[2], 4'h1);
    chk({tag, " R8 done edge"}, done_cyc, 5 * N + 20);
  endtask

  task automatic t_reset();
    do_reset();
    repeat (4) @(negedge clk);
    chk("R1 ctl", ctl, 0); chk("R1 cmd", cmd, 0); chk("R1 addr", addr, 0);
    chk("R1 bank", bank, 0); chk("R1 issue", issue, 0); chk("R1 done", done, 0);
  endtask

  task automatic t_full();
    pulse_start();
    record(5 * N + 30, -1, -1);
    check_program("full");
    chk("R9 derived wait length", slow_cyc, NS + 3);
  endtask

  task automatic t_restart_mid();
    do_reset();
    pulse_start();
    record(5 * N + 30, s_cyc + N + 5, s_cyc + 3 * N + 9);
    check_program("R10 restart");
  endtask

  task automatic t_after_done();
    int bad = 0;
    pulse_start();
    for (int k = 0; k < 3 * N; k++) begin
      @(negedge clk);
      if (ctl != 4'h1 || !done || issue) bad++;
    end
    chk("R10 start after done ignored", bad, 0);
    chk("R8 done held", done, 1);
  endtask

  initial begin
    t_reset();
    t_full();
    t_restart_mid();
    t_after_done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected below 50000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule